// File: doc/BRIEF.md
# Alternate Protocol Negotiation Controller

This block sits beside the link-training logic of a dual-mode serial port. The port uses the same physical signalling whether it carries the baseline serial protocol (PCIe) or the alternate coherent protocol (CXL). Each time the link comes up, the port trains and runs in baseline mode first. The controller then decides once whether to switch to the alternate protocol. The decision is two-sided. The local side sends an offer only if its enable bit is set. The port moves to alternate mode only if the partner answers that offer with an accept message.

Every other outcome leaves the port in baseline mode without any further action: a partner that never answers, a refusal, or any message the controller does not recognise. The chosen mode is then locked and holds until the link drops. A link drop clears the lock, and the next link-up negotiates from the beginning. The offer code and the accept code are parameters. The response window is a run-time input counted in clock cycles.

Top module: `altproto_negotiator`

## Requirements
- R1: While `rst` is high, and in the cycle after any cycle with `link_up` low, `mode_locked`, `mode_alt` and `tx_msg_valid` are all 0.
- R2: After `link_up` rises, and until `train_done` is seen, the controller sends no message and reports `mode_locked`=0 and `mode_alt`=0, because the port runs in baseline mode.
- R3: If `alt_enable` is 0 in the cycle `train_done` is seen, the next cycle shows `mode_locked`=1 and `mode_alt`=0, and no offer is ever sent on that link-up.
- R4: If `alt_enable` is 1 in the cycle `train_done` is seen, the next cycle shows `tx_msg_valid`=1 with `tx_msg_code`=4'h1 (the offer) for exactly one cycle. `tx_msg_code` is 0 whenever `tx_msg_valid` is 0.
- R5: An accept message (`rx_msg_valid`=1 with code 4'h2) received inside the response window gives `mode_locked`=1 and `mode_alt`=1 in the next cycle.
- R6: A refusal message (code 4'h3) received inside the window gives `mode_locked`=1 and `mode_alt`=0 in the next cycle.
- R7: Any other code received inside the window (for example 4'h0 or 4'h9) is treated as a refusal and locks baseline mode in the next cycle.
- R8: The response window lasts max(`timeout_cycles`,1) cycles. It starts in the cycle after the offer is sent. If no message arrives in the window, baseline mode locks in the cycle after the window ends. A message that arrives in the last cycle of the window is still honoured. `timeout_cycles` is held stable during a negotiation.
- R9: Once locked, the mode and the lock stay unchanged for as long as `link_up` stays high, whatever happens on `rx_msg_*`, `train_done` or `alt_enable`.
- R10: A link drop in any state clears the lock. The next link-up renegotiates from scratch.
- R11: Messages received before the offer is sent are ignored. They cause no lock and are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Physical link is up |
| train_done | input | 1 | Baseline training has completed |
| alt_enable | input | 1 | Local side supports and allows the alternate protocol |
| timeout_cycles | input | 16 | Response window length in cycles |
| rx_msg_valid | input | 1 | Negotiation message from partner is valid |
| rx_msg_code | input | 4 | Received message code |
| tx_msg_valid | output | 1 | Negotiation message to partner is valid |
| tx_msg_code | output | 4 | Message code sent to partner |
| mode_alt | output | 1 | 1 = alternate protocol selected, 0 = baseline |
| mode_locked | output | 1 | Mode decision is final for this link-up |

## Verification
Every output of the block comes from a register. Each result therefore appears exactly one clock edge after the input that causes it. This covers the offer after `train_done`, the lock after a response, and the cleared flags after a link drop. The single exception is the timeout lock, which comes max(`timeout_cycles`,1) edges after the window opens. The bench changes inputs shortly after a rising edge and reads the outputs after the following edge. Each check therefore sees the first cycle in which the result is due. The timeout cases check one cycle before the expiry and again at the expiry, which pins the window length to an exact cycle.

// File: rtl/anp_pkg.sv
`timescale 1ns/1ps
package anp_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_TRAIN,
    ST_OFFER,
    ST_WAIT,
    ST_LOCK_ALT,
    ST_LOCK_BASE
  } anp_state_e;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_ACCEPT,
    RSP_REFUSE
  } anp_rsp_e;
endpackage

// File: rtl/anp_msg_decode.sv
`timescale 1ns/1ps
module anp_msg_decode
  import anp_pkg::*;
#(
  parameter int MSG_W       = 4,
  parameter int CODE_ACCEPT = 2
) (
  input  logic             rx_valid,
  input  logic [MSG_W-1:0] rx_code,
  output anp_rsp_e         rsp
);
  localparam logic [MSG_W-1:0] ACC = MSG_W'(CODE_ACCEPT);

  // Only an exact accept counts; every other code, known or not, refuses.
  always_comb begin
    if (!rx_valid)          rsp = RSP_NONE;
    else if (rx_code == ACC) rsp = RSP_ACCEPT;
    else                    rsp = RSP_REFUSE;
  end
endmodule

// File: rtl/anp_wait_timer.sv
`timescale 1ns/1ps
module anp_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  // Last window cycle reached; a limit of 0 behaves like 1.
  assign expire  = run && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expire)  cnt <= cnt_inc[CNT_W-1:0];
  end

  // Counter restarts from zero whenever the window is not open (R8).
  assert_window_restart_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/anp_fsm.sv
`timescale 1ns/1ps
module anp_fsm
  import anp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       link_up,
  input  logic       train_done,
  input  logic       alt_enable,
  input  anp_rsp_e   rsp,
  input  logic       expire,
  output anp_state_e state,
  output logic       tx_offer,
  output logic       mode_alt,
  output logic       mode_locked
);
  anp_state_e nxt;

  always_comb begin
    nxt = state;
    if (!link_up) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET:     nxt = ST_TRAIN;
        ST_TRAIN:     if (train_done) nxt = alt_enable ? ST_OFFER : ST_LOCK_BASE;
        ST_OFFER:     nxt = ST_WAIT;
        ST_WAIT: begin
          if (rsp == RSP_ACCEPT)      nxt = ST_LOCK_ALT;
          else if (rsp == RSP_REFUSE) nxt = ST_LOCK_BASE;
          else if (expire)            nxt = ST_LOCK_BASE;
        end
        ST_LOCK_ALT:  nxt = ST_LOCK_ALT;
        ST_LOCK_BASE: nxt = ST_LOCK_BASE;
        default:      nxt = ST_RESET;
      endcase
    end
  end

  // Outputs are registered from the next state so they align with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RESET;
      tx_offer    <= 1'b0;
      mode_alt    <= 1'b0;
      mode_locked <= 1'b0;
    end else begin
      state       <= nxt;
      tx_offer    <= (nxt == ST_OFFER);
      mode_alt    <= (nxt == ST_LOCK_ALT);
      mode_locked <= (nxt == ST_LOCK_ALT) || (nxt == ST_LOCK_BASE);
    end
  end

  assert_train_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRAIN) |-> (!mode_locked && !tx_offer && !mode_alt));

  assert_disabled_no_offer_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRAIN && link_up && train_done && !alt_enable)
      |=> (mode_locked && !mode_alt && !tx_offer));

  assert_offer_single_R4: assert property (@(posedge clk) disable iff (rst)
    tx_offer |=> !tx_offer);

  assert_alt_locked_R5: assert property (@(posedge clk) disable iff (rst)
    mode_alt |-> mode_locked);

  assert_alt_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_alt) |-> $past(rsp == RSP_ACCEPT));

  assert_refuse_base_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && link_up && rsp == RSP_REFUSE) |=> (mode_locked && !mode_alt));

  assert_timeout_base_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && link_up && rsp == RSP_NONE && expire)
      |=> (mode_locked && !mode_alt));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_locked && link_up) |=> (mode_locked && $stable(mode_alt)));

  assert_drop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!mode_locked && !mode_alt && !tx_offer));
endmodule

// File: rtl/altproto_negotiator.sv
`timescale 1ns/1ps
module altproto_negotiator
  import anp_pkg::*;
#(
  parameter int MSG_W       = 4,
  parameter int CNT_W       = 16,
  parameter int CODE_OFFER  = 1,
  parameter int CODE_ACCEPT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             train_done,
  input  logic             alt_enable,
  input  logic [CNT_W-1:0] timeout_cycles,
  input  logic             rx_msg_valid,
  input  logic [MSG_W-1:0] rx_msg_code,
  output logic             tx_msg_valid,
  output logic [MSG_W-1:0] tx_msg_code,
  output logic             mode_alt,
  output logic             mode_locked
);
  localparam logic [MSG_W-1:0] OFFER = MSG_W'(CODE_OFFER);

  anp_rsp_e   rsp;
  anp_state_e state;
  logic       expire;
  logic       in_wait;
  logic       tx_offer;

  assign in_wait = (state == ST_WAIT);

  anp_msg_decode #(.MSG_W(MSG_W), .CODE_ACCEPT(CODE_ACCEPT)) u_decode (
    .rx_valid (rx_msg_valid),
    .rx_code  (rx_msg_code),
    .rsp      (rsp)
  );

  anp_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (in_wait),
    .limit  (timeout_cycles),
    .expire (expire)
  );

  anp_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .link_up     (link_up),
    .train_done  (train_done),
    .alt_enable  (alt_enable),
    .rsp         (rsp),
    .expire      (expire),
    .state       (state),
    .tx_offer    (tx_offer),
    .mode_alt    (mode_alt),
    .mode_locked (mode_locked)
  );

  assign tx_msg_valid = tx_offer;
  assign tx_msg_code  = tx_offer ? OFFER : '0;

  assert_tx_code_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_msg_valid |-> (tx_msg_code == '0));
endmodule

// File: tb/altproto_negotiator_tb.sv
`timescale 1ns/1ps
module altproto_negotiator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 1'b0;
  logic        train_done = 1'b0;
  logic        alt_enable = 1'b0;
  logic [15:0] timeout_cycles = 16'd8;
  logic        rx_msg_valid = 1'b0;
  logic [3:0]  rx_msg_code = 4'h0;
  logic        tx_msg_valid;
  logic [3:0]  tx_msg_code;
  logic        mode_alt;
  logic        mode_locked;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  altproto_negotiator dut_i (
    .clk            (clk),
    .rst            (rst),
    .link_up        (link_up),
    .train_done     (train_done),
    .alt_enable     (alt_enable),
    .timeout_cycles (timeout_cycles),
    .rx_msg_valid   (rx_msg_valid),
    .rx_msg_code    (rx_msg_code),
    .tx_msg_valid   (tx_msg_valid),
    .tx_msg_code    (tx_msg_code),
    .mode_alt       (mode_alt),
    .mode_locked    (mode_locked)
  );

  typedef struct packed {
    logic        en;
    logic        send;
    logic [3:0]  code;
    logic [7:0]  dly;
    logic [15:0] tmo;
    logic        exp_alt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'h2, 8'd0, 16'd8,  1'b1},  // accept at once
    '{1'b1, 1'b1, 4'h3, 8'd2, 16'd8,  1'b0},  // refusal
    '{1'b1, 1'b1, 4'h0, 8'd1, 16'd8,  1'b0},  // malformed zero
    '{1'b1, 1'b1, 4'h9, 8'd0, 16'd8,  1'b0},  // unknown code
    '{1'b1, 1'b0, 4'h0, 8'd0, 16'd5,  1'b0},  // silent partner
    '{1'b0, 1'b0, 4'h0, 8'd0, 16'd8,  1'b0},  // local disable
    '{1'b1, 1'b1, 4'h2, 8'd7, 16'd8,  1'b1},  // accept in last window cycle
    '{1'b1, 1'b0, 4'h0, 8'd0, 16'd1,  1'b0},  // one-cycle window
    '{1'b1, 1'b1, 4'h2, 8'd3, 16'd20, 1'b1}   // accept mid window
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bring_to_wait(input logic [15:0] tmo);
    link_up = 1'b0; rx_msg_valid = 1'b0; train_done = 1'b0;
    tick();
    link_up = 1'b1; alt_enable = 1'b1; timeout_cycles = tmo;
    tick(); tick();
    train_done = 1'b1;
    tick();
    train_done = 1'b0;
    tick();
  endtask

  task automatic run_vec(input vec_t v);
    int teff;
    string tag;
    teff = (v.tmo == 0) ? 1 : int'(v.tmo);
    tag  = v.exp_alt ? "R5" : ((v.code == 4'h3) ? "R6" : "R7");
    link_up = 1'b0; rx_msg_valid = 1'b0; train_done = 1'b0;
    tick();
    check("R10 drop clears lock", mode_locked, 0);
    link_up = 1'b1; alt_enable = v.en; timeout_cycles = v.tmo;
    tick(); tick();
    check("R2 training quiet lock", mode_locked, 0);
    check("R2 training quiet tx", tx_msg_valid, 0);
    train_done = 1'b1;
    tick();
    train_done = 1'b0;
    check("R4 offer valid follows enable", tx_msg_valid, v.en);
    if (!v.en) begin
      check("R3 disabled locks", mode_locked, 1);
      check("R3 disabled baseline", mode_alt, 0);
      tick();
      check("R3 no offer later", tx_msg_valid, 0);
      return;
    end
    check("R4 offer code", tx_msg_code, 1);
    tick();
    check("R4 offer one cycle", tx_msg_valid, 0);
    check("R4 code idle", tx_msg_code, 0);
    if (v.send) begin
      repeat (v.dly) tick();
      check("R8 still waiting", mode_locked, 0);
      rx_msg_valid = 1'b1; rx_msg_code = v.code;
      tick();
      rx_msg_valid = 1'b0;
      check({tag, " locked"}, mode_locked, 1);
      check({tag, " mode"}, mode_alt, v.exp_alt);
    end else begin
      repeat (teff - 1) tick();
      check("R8 not expired early", mode_locked, 0);
      tick();
      check("R8 timeout locks", mode_locked, 1);
      check("R8 timeout baseline", mode_alt, 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst = 1'b1; link_up = 1'b1; train_done = 1'b1; alt_enable = 1'b1;
    #1;
    tick(); tick();
    check("R1 reset lock", mode_locked, 0);
    check("R1 reset alt", mode_alt, 0);
    check("R1 reset tx", tx_msg_valid, 0);
    rst = 1'b0; link_up = 1'b0; train_done = 1'b0;
    tick();
    check("R1 link down lock", mode_locked, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: accept before any offer is ignored and forgotten
    link_up = 1'b0; tick();
    link_up = 1'b1; alt_enable = 1'b1; timeout_cycles = 16'd3;
    tick();
    rx_msg_valid = 1'b1; rx_msg_code = 4'h2;
    tick();
    rx_msg_valid = 1'b0;
    check("R11 early accept no lock", mode_locked, 0);
    check("R11 early accept no alt", mode_alt, 0);
    train_done = 1'b1; tick(); train_done = 1'b0;
    tick();
    tick(); tick(); tick();
    check("R11 early accept not remembered lock", mode_locked, 1);
    check("R11 early accept not remembered mode", mode_alt, 0);

    // R9: locked alternate holds through noise
    bring_to_wait(16'd6);
    rx_msg_valid = 1'b1; rx_msg_code = 4'h2;
    tick();
    check("R5 accept locks alt", mode_alt, 1);
    rx_msg_code = 4'h3; train_done = 1'b1; alt_enable = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R9 hold lock", mode_locked, 1);
      check("R9 hold alt", mode_alt, 1);
      check("R9 no tx", tx_msg_valid, 0);
    end
    rx_msg_valid = 1'b0; train_done = 1'b0;

    // R10: drop while locked alternate, then renegotiate disabled
    link_up = 1'b0;
    tick();
    check("R10 drop clears alt", mode_alt, 0);
    check("R10 drop clears lock", mode_locked, 0);
    link_up = 1'b1; alt_enable = 1'b0;
    tick();
    train_done = 1'b1; tick(); train_done = 1'b0;
    check("R10 fresh negotiation lock", mode_locked, 1);
    check("R10 fresh negotiation baseline", mode_alt, 0);

    // R10: drop while waiting for response
    bring_to_wait(16'd10);
    link_up = 1'b0;
    rx_msg_valid = 1'b1; rx_msg_code = 4'h2;
    tick();
    rx_msg_valid = 1'b0;
    check("R10 drop in wait lock", mode_locked, 0);
    check("R10 drop in wait alt", mode_alt, 0);

    // R8: zero window acts as one cycle
    bring_to_wait(16'd0);
    check("R8 zero window open", mode_locked, 0);
    tick();
    check("R8 zero window expires", mode_locked, 1);
    check("R8 zero window baseline", mode_alt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule